// File: doc/BRIEF.md
# Programmable Watchdog Timer with Steered Expiry

This block supervises a processor with a countdown that the processor must keep restarting. Software programs one 8-bit control register with a multiplier, a resolution code and a steering bit. The countdown advances on a single-cycle 16 Hz enable supplied by an external prescaler. The timeout is the multiplier times the selected resolution. Two things restart the countdown from its full period: any write to the control register, and any edge, rising or falling, on an asynchronous kick pin.

When the countdown runs out, a sticky flag is set. The steering bit then selects one of two actions. With steering clear, an active-low interrupt line goes low and stays low until software writes zero to the control register. With steering set, an active-low reset line pulses low for a fixed number of 16 Hz ticks. In the same cycle the control register and four neighbouring enable bits are cleared, which leaves the watchdog disarmed.

Top module: `wdog_steer`

## Requirements
- R1: After a synchronous reset, `cfg_q` and `aux_q` are zero, `wd_flag` is 0, and `irq_n` and `sysrst_n` are 1.
- R2: The control register is laid out as: bit 7 = steering, bits 6..2 = multiplier M, bits 1..0 = resolution code. The code gives a unit length in 16 Hz ticks: 00 = 1, 01 = 4, 10 = 16, 11 = 64. Expiry occurs on exactly the M×unit-th tick after the restart, and on no earlier tick.
- R3: Every write to the control register restarts the countdown with the written multiplier, and this holds even when the same value is rewritten.
- R4: A rising or a falling edge on `kick_pin` restarts the countdown. The pin passes through a two-flop synchronizer, and the restart takes effect within 3 clock cycles of the pin changing.
- R5: While the multiplier is zero, no expiry occurs and no output changes.
- R6: On expiry with steering 0, `wd_flag` is set and `irq_n` goes low. Both hold until a write of 0x00. A write of any other value leaves them unchanged.
- R7: On expiry with steering 1, `wd_flag` is set, `irq_n` stays high, and `sysrst_n` is low for exactly PULSE_TICKS ticks (default 4).
- R8: On expiry with steering 1, `cfg_q` and `aux_q` are cleared to zero in the expiry cycle.
- R9: A register write in the same cycle as the tick that would expire the countdown takes priority. No expiry occurs, and the countdown restarts.
- R10: `aux_we` loads `aux_wdata` into `aux_q`. If an aux write lands in the same cycle as a steering-1 expiry, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Single-cycle 16 Hz enable |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| aux_we | input | 1 | Enable-bits write strobe |
| aux_wdata | input | 4 | Enable-bits write data |
| kick_pin | input | 1 | Asynchronous kick input |
| cfg_q | output | 8 | Control register contents |
| aux_q | output | 4 | Neighbouring enable bits |
| wd_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low latched interrupt |
| sysrst_n | output | 1 | Active-low reset pulse |

## Verification
Two events can fall in the same cycle: a restart and the tick that would end the countdown. The bench provokes this by raising `tick16` and `cfg_we` on the same clock edge, with one tick left on a one-tick timeout. It expects the flag to stay low on that tick and to rise on the next tick. A second collision pairs an aux write with a reset-steered expiry and expects `aux_q` to read zero. Around these cases, the bench sweeps every multiplier at the two short resolutions and samples multipliers at the two long ones. It computes each expected expiry tick as M×4^code.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_pin_edge.sv
module wdog_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic kick_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign kick_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int MULT_W   = 5,
  parameter int RES_W    = 2,
  parameter int STEP_LOG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  logic [MULT_W-1:0] load_mult,
  input  logic [RES_W-1:0]  res,
  output logic              expire
);
  localparam int RES_N  = 1 << RES_W;
  localparam int UNIT_W = STEP_LOG * (RES_N - 1);

  logic [UNIT_W-1:0] last_tbl [RES_N];
  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] unit_last;
  logic [MULT_W-1:0] rem_q;
  logic              wrap;
  logic              live;

  for (genvar gi = 0; gi < RES_N; gi++) begin : g_last
    assign last_tbl[gi] = UNIT_W'((1 << (STEP_LOG * gi)) - 1);
  end

  assign unit_last = last_tbl[res];
  assign wrap      = (unit_q == unit_last);
  assign live      = (rem_q != '0);
  assign expire    = tick && !restart && live && wrap && (rem_q == MULT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= '0;
      rem_q  <= '0;
    end else if (restart) begin
      unit_q <= '0;
      rem_q  <= load_mult;
    end else if (tick && live) begin
      if (wrap) begin
        unit_q <= '0;
        rem_q  <= rem_q - MULT_W'(1);
      end else begin
        unit_q <= unit_q + UNIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic pulse_n
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick) begin
      if (cnt_q == CNT_W'(PULSE_TICKS - 1)) active_q <= 1'b0;
      else                                  cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign pulse_n = !active_q;
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STEP_LOG    = 2,
  parameter int AUX_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             aux_we,
  input  logic [AUX_W-1:0] aux_wdata,
  input  logic             kick_pin,
  output logic [7:0]       cfg_q,
  output logic [AUX_W-1:0] aux_q,
  output logic             wd_flag,
  output logic             irq_n,
  output logic             sysrst_n
);
  wdog_cfg_t   cfg_r;
  wdog_cfg_t   wr_cfg;
  logic        pin_kick;
  logic        restart;
  logic        expire;
  logic        exp_irq;
  logic        exp_rst;
  logic        zero_wr;
  logic [MULT_W-1:0] load_mult;
  logic [RES_W-1:0]  cur_res;

  assign wr_cfg    = wdog_cfg_t'(cfg_wdata);
  assign restart   = cfg_we || pin_kick;
  assign load_mult = cfg_we ? wr_cfg.mult : cfg_r.mult;
  assign cur_res   = cfg_we ? wr_cfg.res  : cfg_r.res;
  assign exp_irq   = expire && !cfg_r.steer;
  assign exp_rst   = expire &&  cfg_r.steer;
  assign zero_wr   = cfg_we && (cfg_wdata == 8'h00);

  wdog_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin(kick_pin), .kick_o(pin_kick)
  );

  wdog_timebase #(.MULT_W(MULT_W), .RES_W(RES_W), .STEP_LOG(STEP_LOG)) u_tb (
    .clk(clk), .rst(rst), .tick(tick16), .restart(restart),
    .load_mult(load_mult), .res(cur_res), .expire(expire)
  );

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .start(exp_rst), .tick(tick16), .pulse_n(sysrst_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r   <= '0;
      aux_q   <= '0;
      wd_flag <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      if (exp_rst) begin
        cfg_r <= '0;
        aux_q <= '0;
      end else begin
        if (cfg_we) cfg_r <= wr_cfg;
        if (aux_we) aux_q <= aux_wdata;
      end
      if (expire)       wd_flag <= 1'b1;
      else if (zero_wr) wd_flag <= 1'b0;
      if (exp_irq)      irq_n <= 1'b0;
      else if (zero_wr) irq_n <= 1'b1;
    end
  end

  assign cfg_q = cfg_r;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int AUX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick16,
  input logic             cfg_we,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_q,
  input logic [AUX_W-1:0] aux_q,
  input logic             wd_flag,
  input logic             irq_n,
  input logic             sysrst_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (irq_n && sysrst_n && !wd_flag && cfg_q == 8'h00));

  assert_expire_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag) |-> $past(tick16));

  assert_zero_mult_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag) |-> $past(cfg_q[6:2] != 5'd0));

  assert_irq_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(cfg_we && cfg_wdata == 8'h00));

  assert_irq_flagged_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> wd_flag);

  assert_pulse_not_irq_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sysrst_n) |-> (wd_flag && irq_n));

  assert_pulse_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sysrst_n) |-> (cfg_q == 8'h00 && aux_q == '0));

  assert_write_blocks_expiry_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !$rose(wd_flag));
endmodule

bind wdog_steer wdog_steer_chk #(.AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .aux_q(aux_q), .wd_flag(wd_flag), .irq_n(irq_n), .sysrst_n(sysrst_n)
);

// File: tb/sim_wdog_steer.sv
module sim_wdog_steer;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       aux_we = 1'b0;
  logic [3:0] aux_wdata = 4'h0;
  logic       kick_pin = 1'b0;
  logic [7:0] cfg_q;
  logic [3:0] aux_q;
  logic       wd_flag, irq_n, sysrst_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_steer #(.PULSE_TICKS(PULSE)) u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .kick_pin(kick_pin),
    .cfg_q(cfg_q), .aux_q(aux_q), .wd_flag(wd_flag), .irq_n(irq_n), .sysrst_n(sysrst_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    idle(2);
  endtask

  task automatic wr_aux(input logic [3:0] v);
    @(negedge clk);
    aux_we = 1'b1; aux_wdata = v;
    @(negedge clk);
    aux_we = 1'b0;
    idle(2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      idle(6);
    end
  endtask

  task automatic sweep_case(input int m, input int code);
    int n;
    n = m * (1 << (2 * code));
    wr_cfg(8'h00);
    wr_cfg(8'((m << 2) | code));
    ticks(n - 1);
    check(wd_flag == 1'b0 && irq_n == 1'b1, "R2", "early expiry", wd_flag, 0);
    ticks(1);
    check(wd_flag == 1'b1 && irq_n == 1'b0, "R2", "expiry on period tick", irq_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run hung actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check(cfg_q == 8'h00 && aux_q == 4'h0, "R1", "regs after reset", cfg_q, 0);
    check(wd_flag == 1'b0, "R1", "flag after reset", wd_flag, 0);
    check(irq_n && sysrst_n, "R1", "outputs after reset", {irq_n, sysrst_n}, 3);

    // R2 sweep: every multiplier at codes 00 and 01, samples at 10 and 11
    for (int m = 1; m < 32; m++) sweep_case(m, 0);
    for (int m = 1; m < 32; m++) sweep_case(m, 1);
    sweep_case(1, 2); sweep_case(3, 2); sweep_case(7, 2);
    sweep_case(1, 3); sweep_case(2, 3);

    // R6: a nonzero write leaves the interrupt latched, a 0x00 write releases it
    wr_cfg(8'h08);
    check(irq_n == 1'b0 && wd_flag == 1'b1, "R6", "nonzero write keeps irq", irq_n, 0);
    wr_cfg(8'h00);
    check(irq_n == 1'b1 && wd_flag == 1'b0, "R6", "zero write clears irq", irq_n, 1);

    // R3: a rewrite of the same value restarts (M=3, code 00 -> 3 ticks)
    wr_cfg(8'h0C);
    ticks(2);
    wr_cfg(8'h0C);
    ticks(2);
    check(wd_flag == 1'b0, "R3", "rewrite restarted count", wd_flag, 0);
    ticks(1);
    check(wd_flag == 1'b1, "R3", "expiry after rewrite", wd_flag, 1);
    wr_cfg(8'h00);

    // R4: rising and falling pin edges restart (M=2, code 00)
    wr_cfg(8'h08);
    ticks(1);
    @(negedge clk); kick_pin = 1'b1; idle(4);
    ticks(1);
    check(wd_flag == 1'b0, "R4", "rising edge restart", wd_flag, 0);
    @(negedge clk); kick_pin = 1'b0; idle(4);
    ticks(1);
    check(wd_flag == 1'b0, "R4", "falling edge restart", wd_flag, 0);
    ticks(1);
    check(wd_flag == 1'b1 && irq_n == 1'b0, "R4", "expiry after kicks", wd_flag, 1);
    wr_cfg(8'h00);

    // R5: zero multiplier never expires
    wr_cfg(8'h01);
    ticks(40);
    check(wd_flag == 1'b0 && irq_n && sysrst_n, "R5", "zero mult quiet", wd_flag, 0);
    wr_cfg(8'h00);

    // R9: a write on the expiring tick wins (M=1, code 00)
    wr_cfg(8'h04);
    @(negedge clk);
    tick16 = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h04;
    @(negedge clk);
    tick16 = 1'b0; cfg_we = 1'b0;
    idle(4);
    check(wd_flag == 1'b0, "R9", "write beats expiry", wd_flag, 0);
    ticks(1);
    check(wd_flag == 1'b1, "R9", "expiry on following tick", wd_flag, 1);
    wr_cfg(8'h00);

    // R10: aux write port stores
    wr_aux(4'hA);
    check(aux_q == 4'hA, "R10", "aux store", aux_q, 10);

    // R7 and R8: reset-steered expiry (0x84: steer, M=1, code 00)
    wr_aux(4'hF);
    wr_cfg(8'h84);
    ticks(1);
    check(sysrst_n == 1'b0 && irq_n == 1'b1, "R7", "pulse not irq", {sysrst_n, irq_n}, 1);
    check(wd_flag == 1'b1, "R7", "flag on reset expiry", wd_flag, 1);
    check(cfg_q == 8'h00, "R8", "cfg cleared", cfg_q, 0);
    check(aux_q == 4'h0, "R8", "aux cleared", aux_q, 0);
    ticks(PULSE - 1);
    check(sysrst_n == 1'b0, "R7", "pulse still low", sysrst_n, 0);
    ticks(1);
    check(sysrst_n == 1'b1, "R7", "pulse ended", sysrst_n, 1);
    ticks(10);
    check(sysrst_n == 1'b1 && irq_n == 1'b1, "R8", "disarmed after clear", sysrst_n, 1);

    // R10: aux write colliding with reset-steered expiry
    wr_cfg(8'h00);
    wr_aux(4'hF);
    wr_cfg(8'h84);
    @(negedge clk);
    tick16 = 1'b1; aux_we = 1'b1; aux_wdata = 4'h5;
    @(negedge clk);
    tick16 = 1'b0; aux_we = 1'b0;
    idle(4);
    check(aux_q == 4'h0, "R10", "clear beats aux write", aux_q, 0);
    ticks(PULSE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule